// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer and Readout

This block is the digital half of a 12-bit successive-approximation converter. A host pulls the active-low select low to sample and start a conversion. The block then steps through the result bits on its own system clock, driving a trial code to an external capacitive DAC and reading back one comparator bit per step. The serial data line stays low while the conversion runs. It goes high to mark completion, and the result then leaves MSB first, one bit per falling edge of the host's serial clock. Clock edges after the last data bit give zeros.

The analog side is reduced to ports. `hold` commands the track/hold, `dac_code` is the trial word, and `cmp_in` reports whether that word does not exceed the held sample. The select, serial clock and shutdown inputs are asynchronous to the system clock. Each passes through a synchroniser, and edges are found on the synchronised copies.

The controller has six states:
- ST_OFF: powered down while shutdown is low.
- ST_WAKE: counts the wake-up interval.
- ST_ACQ: counts the acquisition interval after an aborted conversion.
- ST_READY: tracking the input and accepting a start.
- ST_CONV: converting.
- ST_SHIFT: the result is ready to be read.

Its transitions are:
- Power-up: ST_OFF to ST_WAKE when shutdown is released.
- Wake done: ST_WAKE to ST_READY.
- Acquire done: ST_ACQ to ST_READY.
- Start: ST_READY to ST_CONV on a select fall.
- Abort: ST_CONV to ST_ACQ on a select rise.
- Complete: ST_CONV to ST_SHIFT when the last bit is decided.
- Release: ST_SHIFT to ST_READY on a select rise.
- Power-down: from any state to ST_OFF while shutdown is low.

Reset leaves the block in ST_WAKE.

Top module: `adc_serial_ctl`

## Requirements
- R1: After reset, and after shutdown is released, a select fall that comes within WAKE_CYCLES (default 500) system clocks is ignored: `sdo_oe` and `hold` stay 0.
- R2: While select is high, `sdo_oe` is 0 within 6 system clocks of the rise.
- R3: An accepted select fall sets `hold`=1, `sdo_oe`=1 and `sdo`=0 within 5 system clocks. `sdo` rises between DATA_W*STEP_CYCLES and DATA_W*STEP_CYCLES+6 clocks after the fall (default 48 to 54). `hold` returns to 0 by then.
- R4: In ST_SHIFT, `sdo` changes only on serial clock falls. It holds the end-of-conversion 1 until the first fall. The first fall presents bit 11 (MSB), and the next falls present bits 10 down to 0.
- R5: Serial clock falls after the LSB, while select stays low, drive `sdo`=0.
- R6: The result is straight binary. With `cmp_in`=1 meaning "trial code <= sample", the result equals the sample code for every value from 0 to 4095.
- R7: A select rise during conversion aborts it: `hold`=0, `sdo_oe`=0 and `dac_code`=0. A new select fall within ACQ_CYCLES (default 188) is ignored, and one after that interval converts normally.
- R8: Shutdown low forces `hold`=0 and `sdo_oe`=0 within 6 clocks, aborting any conversion. After release, the wake-up interval of R1 applies.
- R9: Serial clock falls during a conversion have no effect on the result.
- R10: After a completed read, a new select fall 10 clocks after the select rise is accepted, with no acquisition wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, times the conversion steps |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; a fall starts a conversion |
| sclk | input | 1 | Host serial clock; falling edges shift the result |
| shdn_n | input | 1 | Active-low shutdown |
| cmp_in | input | 1 | Comparator: 1 when the trial code does not exceed the sample |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| hold | output | 1 | Track/hold control, 1 = hold |
| dac_code | output | DATA_W | Trial code for the capacitive DAC |

## Verification
Two windows are hard to reach from the ports. The first is a select fall that lands inside the acquisition interval after an abort. The second is one that lands inside the wake-up interval after shutdown. Both need a conversion to be started and then cut short at a chosen point, followed by a fresh fall a few clocks later. The bench does this with timed select pulses and shutdown pulses placed in the middle of a conversion. It also toggles the serial clock during a conversion to show that those edges leave the result unchanged.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_ACQ,
        ST_READY,
        ST_CONV,
        ST_SHIFT
    } ctl_state_t;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_in};
    end

    assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int DATA_W      = 12,
    parameter int STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

    logic [IDX_W-1:0]  bit_idx;
    logic [STEP_W-1:0] step;
    logic [DATA_W-1:0] cur_bit;
    logic [DATA_W-1:0] kept;
    logic              step_end;

    always_comb begin
        cur_bit  = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
        kept     = cmp_in ? trial : (trial & ~cur_bit);
        step_end = (step == STEP_W'(STEP_CYCLES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            bit_idx <= '0;
            step    <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy  <= 1'b0;
                trial <= '0;
            end else if (start) begin
                busy    <= 1'b1;
                trial   <= {1'b1, {(DATA_W-1){1'b0}}};
                bit_idx <= IDX_W'(DATA_W - 1);
                step    <= '0;
            end else if (busy) begin
                if (step_end) begin
                    step <= '0;
                    if (bit_idx == '0) begin
                        trial <= kept;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        trial   <= kept | (cur_bit >> 1);
                        bit_idx <= bit_idx - 1'b1;
                    end
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // R6: bits below the one under test are still clear while converting
    a_r6_lower_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((trial & (cur_bit - 1'b1)) == '0));

    // R6: completion only follows a running conversion
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    output logic              sdo
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (clear) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (load) begin
            sh  <= data;
            sdo <= 1'b1;
        end else if (shift) begin
            sdo <= sh[DATA_W-1];
            sh  <= {sh[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
    import adc_ctl_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int STEP_CYCLES = 4,
    parameter int ACQ_CYCLES  = 188,
    parameter int WAKE_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              shdn_n,
    input  logic              cmp_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              hold,
    output logic [DATA_W-1:0] dac_code
);
    localparam int CNT_MAX = (WAKE_CYCLES > ACQ_CYCLES) ? WAKE_CYCLES : ACQ_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic cs_s, sclk_s, shdn_s;
    logic cs_d, sclk_d;
    logic cs_fall, cs_rise, sclk_fall;
    logic sar_busy, sar_done, sar_start, sar_abort;
    logic sh_load, sh_shift;
    logic cnt_done;
    logic [CNT_W-1:0] cnt;
    ctl_state_t state, nxt;

    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_in(cs_n), .q_out(cs_s));
    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_in(sclk), .q_out(sclk_s));
    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_shdn (
        .clk(clk), .rst_n(rst_n), .d_in(shdn_n), .q_out(shdn_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sclk_fall = sclk_d & ~sclk_s;

    always_comb begin
        cnt_done = 1'b0;
        if (state == ST_WAKE) cnt_done = (cnt == CNT_W'(WAKE_CYCLES - 1));
        if (state == ST_ACQ)  cnt_done = (cnt == CNT_W'(ACQ_CYCLES - 1));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (shdn_s)   nxt = ST_WAKE;
            ST_WAKE:  if (cnt_done) nxt = ST_READY;
            ST_ACQ:   if (cnt_done) nxt = ST_READY;
            ST_READY: if (cs_fall)  nxt = ST_CONV;
            ST_CONV: begin
                if (cs_rise)       nxt = ST_ACQ;
                else if (sar_done) nxt = ST_SHIFT;
            end
            ST_SHIFT: if (cs_rise)  nxt = ST_READY;
            default:                nxt = ST_OFF;
        endcase
        if (!shdn_s) nxt = ST_OFF;
    end

    // state register and interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAKE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else if (state == ST_WAKE || state == ST_ACQ) cnt <= cnt + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        hold      = (state == ST_CONV);
        sdo_oe    = (state == ST_CONV) || (state == ST_SHIFT);
        sar_start = (state != ST_CONV) && (nxt == ST_CONV);
        sar_abort = (state == ST_CONV) && (nxt != ST_CONV) && (nxt != ST_SHIFT);
        sh_load   = (state == ST_CONV) && (nxt == ST_SHIFT);
        sh_shift  = (state == ST_SHIFT) && sclk_fall;
    end

    adc_sar_core #(.DATA_W(DATA_W), .STEP_CYCLES(STEP_CYCLES)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(sar_start), .abort(sar_abort),
        .cmp_in(cmp_in), .trial(dac_code), .busy(sar_busy), .done(sar_done));

    adc_out_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(sar_start), .load(sh_load),
        .shift(sh_shift), .data(dac_code), .sdo(sdo));

    // R2: select seen high for two samples means the line is released
    a_r2_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_d) |-> !sdo_oe);

    // R3: the first cycle of ST_SHIFT shows the end-of-conversion 1
    a_r3_eoc_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_CONV) |-> sdo);

    // R4: no serial clock fall, no change on the data line
    a_r4_sdo_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !$past(sclk_fall)) |-> $stable(sdo));

    // R7: holding continues only while select stayed low
    a_r7_hold_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> !$past(cs_s));

    // R8: shutdown silences the outputs on the next cycle
    a_r8_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |=> (!sdo_oe && !hold));

    // R9: the converter is only busy while in ST_CONV
    a_r9_busy_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        sar_busy |-> (state == ST_CONV));
endmodule

// File: tb/adc_serial_ctl_tb_top.sv
module adc_serial_ctl_tb_top;
    localparam int DATA_W = 12;
    localparam int STEP   = 4;
    localparam int ACQ    = 188;
    localparam int WAKE   = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic shdn_n = 1'b1;
    logic cmp_in;
    logic sdo, sdo_oe, hold;
    logic [DATA_W-1:0] dac_code;
    logic [DATA_W-1:0] sample = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] act_q[$];

    always #4 clk = ~clk;

    assign cmp_in = (dac_code <= sample);

    adc_serial_ctl #(.DATA_W(DATA_W), .STEP_CYCLES(STEP), .ACQ_CYCLES(ACQ),
                     .WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .shdn_n(shdn_n),
        .cmp_in(cmp_in), .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold), .dac_code(dac_code));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_conv(input int s, input bit toggle_sclk);
        int cyc;
        logic [DATA_W-1:0] word;
        sample = s[DATA_W-1:0];
        exp_q.push_back(s[DATA_W-1:0]);
        cs_n = 1'b0;
        wait_clk(5);
        cyc = 5;
        check(sdo_oe == 1'b1, "R3 oe on start", int'(sdo_oe), 1);
        check(sdo == 1'b0, "R3 busy low", int'(sdo), 0);
        check(hold == 1'b1, "R3 hold on start", int'(hold), 1);
        if (toggle_sclk) begin
            // R9: serial clock edges while converting
            repeat (3) begin
                sclk = 1'b1; wait_clk(2);
                sclk = 1'b0; wait_clk(2);
                cyc += 4;
            end
        end
        while (sdo !== 1'b1 && cyc < 2000) begin
            wait_clk(1);
            cyc++;
        end
        check(cyc >= DATA_W*STEP && cyc <= DATA_W*STEP + 6, "R3 eoc time", cyc, DATA_W*STEP);
        check(hold == 1'b0, "R3 hold released at eoc", int'(hold), 0);
        word = '0;
        for (int b = 0; b < DATA_W; b++) begin
            sclk = 1'b1;
            wait_clk(4);
            check(sdo == ((b == 0) ? 1'b1 : word[0]), "R4 stable before fall", int'(sdo),
                  (b == 0) ? 1 : int'(word[0]));
            sclk = 1'b0;
            wait_clk(6);
            word = {word[DATA_W-2:0], sdo};
        end
        for (int z = 0; z < 3; z++) begin
            sclk = 1'b1; wait_clk(4);
            sclk = 1'b0; wait_clk(6);
            check(sdo == 1'b0, "R5 trailing zero", int'(sdo), 0);
        end
        act_q.push_back(word);
        cs_n = 1'b1;
        wait_clk(6);
        check(sdo_oe == 1'b0, "R2 released after read", int'(sdo_oe), 0);
    endtask

    // scoreboard monitor: R4 R6
    initial begin
        forever begin
            logic [DATA_W-1:0] e, a;
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            check(a == e, "R6 R4 result", int'(a), int'(e));
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check(sdo_oe == 1'b0, "R2 reset oe", int'(sdo_oe), 0);
        check(hold == 1'b0, "R2 reset hold", int'(hold), 0);

        // R1: start during wake-up is ignored
        cs_n = 1'b0;
        wait_clk(10);
        check(sdo_oe == 1'b0, "R1 wake ignore oe", int'(sdo_oe), 0);
        check(hold == 1'b0, "R1 wake ignore hold", int'(hold), 0);
        cs_n = 1'b1;
        wait_clk(WAKE + 20);

        // R6 patterns, R10 back-to-back after reads
        do_conv(0, 1'b0);
        wait_clk(10);
        do_conv(4095, 1'b0);
        wait_clk(10);
        do_conv(2048, 1'b0);
        wait_clk(10);
        do_conv(12'h555, 1'b0);
        wait_clk(10);
        do_conv(12'hAAA, 1'b0);
        wait_clk(10);
        do_conv(1, 1'b0);
        wait_clk(10);
        do_conv(4094, 1'b0);
        wait_clk(10);

        // R9: serial clock during conversion
        do_conv(12'h9C6, 1'b1);
        wait_clk(10);

        // R7: abort and acquisition window
        sample = 12'h0F0;
        cs_n = 1'b0;
        wait_clk(12);
        cs_n = 1'b1;
        wait_clk(6);
        check(hold == 1'b0, "R7 abort hold", int'(hold), 0);
        check(sdo_oe == 1'b0, "R7 abort oe", int'(sdo_oe), 0);
        check(dac_code == '0, "R7 abort code", int'(dac_code), 0);
        cs_n = 1'b0;
        wait_clk(8);
        check(sdo_oe == 1'b0 && hold == 1'b0, "R7 start inside acquisition ignored",
              int'(sdo_oe), 0);
        cs_n = 1'b1;
        wait_clk(ACQ + 10);
        do_conv(12'h3C3, 1'b0);
        wait_clk(10);

        // R8: shutdown mid conversion, then wake interval
        cs_n = 1'b0;
        wait_clk(20);
        shdn_n = 1'b0;
        wait_clk(6);
        check(sdo_oe == 1'b0 && hold == 1'b0, "R8 shutdown quiet", int'(sdo_oe), 0);
        cs_n = 1'b1;
        wait_clk(10);
        shdn_n = 1'b1;
        wait_clk(20);
        cs_n = 1'b0;
        wait_clk(8);
        check(sdo_oe == 1'b0 && hold == 1'b0, "R8 R1 start during wake ignored",
              int'(sdo_oe), 0);
        cs_n = 1'b1;
        wait_clk(WAKE + 10);
        do_conv(12'h801, 1'b0);

        wait (act_q.size() == 0);
        wait_clk(2);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule